// File: doc/BRIEF.md
# Edge-Capturing Process Interrupt Register

This block serves a group of user input points. Each point has one capture bit. A bit is set by the first low-to-high transition seen on its point, and it stays set until one of several clearing commands or a reset removes it. The block has an interrupt request output. That output is the OR of all capture bits, and it is only enabled while the group is in process-interrupt mode. That mode excludes the external-sync mode, so the two are never set together.

Commands arrive as a one-cycle valid strobe with a 4-bit opcode. A read returns the register on a registered data port. A read-with-clear returns the value that held before the clear. There is also a test facility. It replaces every input receiver with constant ones or constant zeros, so the capture and interrupt path can be exercised without field wiring. Every input goes through a two-flop synchronizer. Edges are judged against the synchronized value of the previous cycle.

Top module: `pi_capture_group`

## Requirements
- R1: While rst_ni is low and after it is released, capture_o is 0, irq_o is 0, pi_mode_o and xsync_mode_o are 0, rd_valid_o is 0, and test forcing is off.
- R2: A 0-to-1 change on points_i[k] (outside test forcing) sets capture_o[k] three rising clock edges later. A level that is held high creates no further capture after the bit is cleared.
- R3: A set capture bit stays set when its input falls or rises again. Only opcode 4'h2 (read-clear), 4'h3 (arm process interrupt), 4'h5 (device reset) or rst_ni clears it.
- R4: Opcode 4'h1 (read) makes rd_valid_o high on the next cycle, with rd_data_o equal to capture_o as it was when the command was taken. capture_o is left unchanged.
- R5: Opcode 4'h2 (read-clear) returns the pre-clear value on rd_data_o the next cycle and clears capture_o. An edge captured on the same clock edge as the clear is kept.
- R6: Opcode 4'h3 (arm process interrupt) sets pi_mode_o, clears xsync_mode_o and clears capture_o. A same-cycle edge is kept.
- R7: irq_o is high exactly when pi_mode_o is high and at least one capture bit is set.
- R8: Opcode 4'h4 (arm external sync) sets xsync_mode_o and clears pi_mode_o, but keeps capture_o. Opcode 4'h6 (halt I/O) clears both modes and keeps capture_o. pi_mode_o and xsync_mode_o are never high together.
- R9: Opcode 4'h5 (device reset) clears capture_o, both modes and test forcing on the next edge.
- R10: Opcode 4'h7 forces every input receiver to 1 and opcode 4'h8 forces every receiver to 0. While forcing is active, points_i has no effect on capture_o. The forced values are captured exactly as real inputs would be. Forcing lasts until a device reset or rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| points_i | input | N_POINTS | User input points, asynchronous |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command opcode |
| capture_o | output | N_POINTS | Capture register |
| rd_data_o | output | N_POINTS | Read result, registered |
| rd_valid_o | output | 1 | Read result valid, one cycle |
| irq_o | output | 1 | Process interrupt request level |
| pi_mode_o | output | 1 | Process-interrupt mode armed |
| xsync_mode_o | output | 1 | External-sync mode armed |

## Verification
The capture path is swept over every ordered pair of 4-bit input patterns on a 4-point build. The first pattern rises from zero and the second follows it. The result must be the OR of both, which separates sticky capture from a plain level sample, and a following clear with the inputs held shows that a level alone does not re-arm a bit. A rise placed exactly on the clear edge separates "edge kept" from "edge lost". Walking through all nonzero patterns under each mode tells the interrupt gating apart from the raw OR. Applying forced ones and zeros while toggling the real inputs shows that the test mux truly isolates the points.

// File: rtl/pi_capture_pkg.sv
package pi_capture_pkg;
  typedef enum logic [3:0] {
    OP_NOP        = 4'h0,
    OP_READ       = 4'h1,
    OP_READ_CLR   = 4'h2,
    OP_ARM_PI     = 4'h3,
    OP_ARM_XSYNC  = 4'h4,
    OP_DEV_RESET  = 4'h5,
    OP_HALT       = 4'h6,
    OP_TEST_ONES  = 4'h7,
    OP_TEST_ZEROS = 4'h8
  } pi_op_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PI    = 2'd1,
    MODE_XSYNC = 2'd2
  } pi_mode_e;
endpackage

// File: rtl/pi_cmd_ctrl.sv
module pi_cmd_ctrl
  import pi_capture_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_op_i,
  output logic       clr_o,
  output logic       rd_o,
  output pi_mode_e   mode_o,
  output logic       test_en_o,
  output logic       test_val_o
);
  pi_op_e   op;
  pi_mode_e mode_q, mode_d;
  logic     test_en_q, test_en_d;
  logic     test_val_q, test_val_d;

  assign op = pi_op_e'(cmd_op_i);

  always_comb begin
    clr_o      = 1'b0;
    rd_o       = 1'b0;
    mode_d     = mode_q;
    test_en_d  = test_en_q;
    test_val_d = test_val_q;
    if (cmd_valid_i) begin
      case (op)
        OP_READ:      rd_o = 1'b1;
        OP_READ_CLR:  begin rd_o = 1'b1; clr_o = 1'b1; end
        OP_ARM_PI:    begin mode_d = MODE_PI; clr_o = 1'b1; end
        OP_ARM_XSYNC: mode_d = MODE_XSYNC;
        OP_DEV_RESET: begin
          mode_d    = MODE_IDLE;
          clr_o     = 1'b1;
          test_en_d = 1'b0;
        end
        OP_HALT:       mode_d = MODE_IDLE;
        OP_TEST_ONES:  begin test_en_d = 1'b1; test_val_d = 1'b1; end
        OP_TEST_ZEROS: begin test_en_d = 1'b1; test_val_d = 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_IDLE;
      test_en_q  <= 1'b0;
      test_val_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      test_en_q  <= test_en_d;
      test_val_q <= test_val_d;
    end
  end

  assign mode_o     = mode_q;
  assign test_en_o  = test_en_q;
  assign test_val_o = test_val_q;
endmodule

// File: rtl/pi_input_front.sv
module pi_input_front #(
  parameter int N_POINTS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_POINTS-1:0] points_i,
  input  logic                test_en_i,
  input  logic                test_val_i,
  output logic [N_POINTS-1:0] sync_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_POINTS-1:0] src;
  logic [N_POINTS-1:0] stage_q [SYNC_STAGES];

  // forced receivers replace the field inputs ahead of the synchronizer
  assign src = test_en_i ? {N_POINTS{test_val_i}} : points_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= src;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/pi_edge_capture.sv
module pi_edge_capture #(
  parameter int N_POINTS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_POINTS-1:0] sync_i,
  input  logic                clr_i,
  input  logic                rd_i,
  output logic [N_POINTS-1:0] capture_o,
  output logic [N_POINTS-1:0] rd_data_o,
  output logic                rd_valid_o
);
  logic [N_POINTS-1:0] prev_q;
  logic [N_POINTS-1:0] cap_q, cap_d;
  logic [N_POINTS-1:0] rise;
  logic [N_POINTS-1:0] rd_data_q;
  logic                rd_valid_q;

  assign rise  = sync_i & ~prev_q;
  // clear drops old bits only; a rise on the clear edge survives
  assign cap_d = (cap_q & ~{N_POINTS{clr_i}}) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      cap_q      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      prev_q     <= sync_i;
      cap_q      <= cap_d;
      rd_valid_q <= rd_i;
      if (rd_i) rd_data_q <= cap_q;
    end
  end

  assign capture_o  = cap_q;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/pi_capture_group.sv
module pi_capture_group
  import pi_capture_pkg::*;
#(
  parameter int N_POINTS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_POINTS-1:0] points_i,
  input  logic                cmd_valid_i,
  input  logic [3:0]          cmd_op_i,
  output logic [N_POINTS-1:0] capture_o,
  output logic [N_POINTS-1:0] rd_data_o,
  output logic                rd_valid_o,
  output logic                irq_o,
  output logic                pi_mode_o,
  output logic                xsync_mode_o
);
  logic                clr;
  logic                rd;
  pi_mode_e            mode;
  logic                test_en;
  logic                test_val;
  logic [N_POINTS-1:0] sync;
  logic [N_POINTS-1:0] cap;

  pi_cmd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .clr_o       (clr),
    .rd_o        (rd),
    .mode_o      (mode),
    .test_en_o   (test_en),
    .test_val_o  (test_val)
  );

  pi_input_front #(
    .N_POINTS    (N_POINTS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .points_i   (points_i),
    .test_en_i  (test_en),
    .test_val_i (test_val),
    .sync_o     (sync)
  );

  pi_edge_capture #(
    .N_POINTS (N_POINTS)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync),
    .clr_i      (clr),
    .rd_i       (rd),
    .capture_o  (cap),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign capture_o    = cap;
  assign pi_mode_o    = (mode == MODE_PI);
  assign xsync_mode_o = (mode == MODE_XSYNC);
  assign irq_o        = pi_mode_o & (|cap);
endmodule

// File: rtl/pi_capture_group_chk.sv
module pi_capture_group_chk #(
  parameter int N_POINTS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [3:0]          cmd_op_i,
  input logic [N_POINTS-1:0] capture_o,
  input logic [N_POINTS-1:0] rd_data_o,
  input logic                rd_valid_o,
  input logic                irq_o,
  input logic                pi_mode_o,
  input logic                xsync_mode_o
);
  logic clearing;
  assign clearing = cmd_valid_i &&
                    (cmd_op_i == 4'h2 || cmd_op_i == 4'h3 || cmd_op_i == 4'h5);

  AST_IRQ_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pi_mode_o && capture_o != '0)); // R7

  AST_IRQ_WHEN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pi_mode_o && capture_o != '0) |-> irq_o); // R7

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pi_mode_o && xsync_mode_o)); // R8

  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clearing |=> ((capture_o & $past(capture_o)) == $past(capture_o))); // R3

  AST_READ_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'h1) |=>
      (rd_valid_o && rd_data_o == $past(capture_o))); // R4

  AST_READ_CLR_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'h2) |=>
      (rd_valid_o && rd_data_o == $past(capture_o))); // R5

  AST_ARM_PI_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'h3) |=> (pi_mode_o && !xsync_mode_o)); // R6

  AST_XSYNC_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 4'h4 || cmd_op_i == 4'h6)) |=>
      (!pi_mode_o && !irq_o)); // R8

  AST_DEV_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'h5) |=> (!pi_mode_o && !xsync_mode_o)); // R9

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (capture_o == '0 && !irq_o && !rd_valid_o); // R1
    end
  end
endmodule

bind pi_capture_group pi_capture_group_chk #(.N_POINTS(N_POINTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .capture_o    (capture_o),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .irq_o        (irq_o),
  .pi_mode_o    (pi_mode_o),
  .xsync_mode_o (xsync_mode_o)
);

// File: tb/pi_capture_group_bench.sv
module pi_capture_group_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] points_i = '0;
  logic         cmd_valid_i = 1'b0;
  logic [3:0]   cmd_op_i = 4'h0;
  logic [N-1:0] capture_o;
  logic [N-1:0] rd_data_o;
  logic         rd_valid_o;
  logic         irq_o;
  logic         pi_mode_o;
  logic         xsync_mode_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pi_capture_group #(.N_POINTS(N), .SYNC_STAGES(2)) u_pi_capture_group (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .points_i     (points_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .capture_o    (capture_o),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .irq_o        (irq_o),
    .pi_mode_o    (pi_mode_o),
    .xsync_mode_o (xsync_mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmd(input logic [3:0] op);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk("R1 capture in reset", 32'(capture_o), 0);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk("R1 capture", 32'(capture_o), 0);
    chk("R1 modes", {30'd0, pi_mode_o, xsync_mode_o}, 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);

    // sweep ordered pattern pairs
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        points_i = '0;
        wait_cyc(3);
        cmd(4'h2);
        points_i = p[N-1:0];
        wait_cyc(3);
        chk("R2 rise captured", 32'(capture_o), 32'(p));
        points_i = q[N-1:0];
        wait_cyc(3);
        chk("R3 sticky merge", 32'(capture_o), 32'(p | q));
        cmd(4'h1);
        chk("R4 read data", 32'(rd_data_o), 32'(p | q));
        chk("R4 read valid", 32'(rd_valid_o), 1);
        chk("R4 read keeps", 32'(capture_o), 32'(p | q));
        cmd(4'h2);
        chk("R5 read-clear data", 32'(rd_data_o), 32'(p | q));
        chk("R5 cleared", 32'(capture_o), 0);
        wait_cyc(3);
        chk("R2 held level no recapture", 32'(capture_o), 0);
      end
    end

    // edge on the clear edge is kept
    points_i = '0;
    wait_cyc(3);
    cmd(4'h2);
    points_i = 4'b0001;
    wait_cyc(3);
    points_i = 4'b0101;
    wait_cyc(2);
    cmd(4'h2);
    chk("R5 pre-clear value", 32'(rd_data_o), 32'h1);
    chk("R5 same-edge rise kept", 32'(capture_o), 32'h4);

    // interrupt gating
    points_i = '0;
    wait_cyc(3);
    cmd(4'h2);
    points_i = 4'b0010;
    wait_cyc(3);
    chk("R7 no irq when idle", 32'(irq_o), 0);
    cmd(4'h3);
    chk("R6 arm sets mode", 32'(pi_mode_o), 1);
    chk("R6 arm clears", 32'(capture_o), 0);
    chk("R7 irq low empty", 32'(irq_o), 0);
    points_i = '0;
    wait_cyc(3);
    for (int p = 1; p < 16; p++) begin
      points_i = p[N-1:0];
      wait_cyc(3);
      chk("R7 irq raised", 32'(irq_o), 1);
      cmd(4'h3);
      chk("R6 rearm clears", 32'(capture_o), 0);
      chk("R7 irq after rearm", 32'(irq_o), 0);
      points_i = '0;
      wait_cyc(3);
    end

    // mode exits
    points_i = 4'b1000;
    wait_cyc(3);
    cmd(4'h4);
    chk("R8 xsync set", {30'd0, pi_mode_o, xsync_mode_o}, 1);
    chk("R8 xsync keeps capture", 32'(capture_o), 32'h8);
    chk("R8 irq off in xsync", 32'(irq_o), 0);
    cmd(4'h3);
    chk("R6 arm leaves xsync", {30'd0, pi_mode_o, xsync_mode_o}, 2);
    points_i = '0;
    wait_cyc(3);
    points_i = 4'b0001;
    wait_cyc(3);
    cmd(4'h6);
    chk("R8 halt clears pi", 32'(pi_mode_o), 0);
    chk("R8 halt keeps capture", 32'(capture_o), 32'h1);
    cmd(4'h4);
    cmd(4'h6);
    chk("R8 halt clears xsync", 32'(xsync_mode_o), 0);
    cmd(4'h3);
    points_i = '0;
    wait_cyc(3);
    points_i = 4'b0110;
    wait_cyc(3);
    cmd(4'h5);
    chk("R9 dev reset clears", 32'(capture_o), 0);
    chk("R9 dev reset mode", {30'd0, pi_mode_o, xsync_mode_o}, 0);

    // forced receivers
    points_i = '0;
    wait_cyc(3);
    cmd(4'h7);
    wait_cyc(4);
    chk("R10 forced ones captured", 32'(capture_o), 32'hF);
    cmd(4'h2);
    points_i = 4'b1010;
    wait_cyc(3);
    points_i = '0;
    wait_cyc(3);
    chk("R10 points ignored under ones", 32'(capture_o), 0);
    cmd(4'h8);
    wait_cyc(4);
    points_i = 4'hF;
    wait_cyc(4);
    chk("R10 points ignored under zeros", 32'(capture_o), 0);
    points_i = '0;
    cmd(4'h7);
    wait_cyc(4);
    chk("R10 zeros to ones captured", 32'(capture_o), 32'hF);
    cmd(4'h5);
    chk("R9 dev reset clears forced", 32'(capture_o), 0);
    wait_cyc(4);
    chk("R9 forcing off no edge", 32'(capture_o), 0);
    points_i = 4'b0101;
    wait_cyc(3);
    chk("R9 real inputs restored", 32'(capture_o), 32'h5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule